// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is the slave end of a two-wire serial link. A host uses the link to load four 8-bit control registers inside a clock generator. The block only receives; it never returns read data. It samples the serial clock (SCL) and data (SDA) lines with a much faster system clock. It detects start and stop conditions, shifts in bytes and acknowledges them by pulling SDA low. It commits the configuration bytes of a fixed-length block write to its registers.

A transfer is ten bytes long. The first is the device address. Two placeholder bytes follow, whose values do not matter. Seven payload bytes come last, and only the final four of them are kept. The registers come out of reset holding working defaults, so a system may leave the link unused. A stop or a new start part-way through a transfer ends that transfer. Bytes that were fully received before that point remain in the registers.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, ctrl0_o = 0x00, ctrl1_o = 0x43, ctrl2_o = 0xEF, ctrl3_o = 0x13, and sda_pull_o = 0.
- R2: The first byte after a start must equal 0xD2 in all eight bits, including the direction bit, which is 0. Any other value is not acknowledged. No later byte of that transfer is acknowledged, and no register changes.
- R3: Byte positions after the address are: position 1 is a command placeholder, position 2 is a count placeholder, and positions 3 to 9 are payload bytes 0 to 6. Payload bytes 3, 4, 5 and 6 (positions 6 to 9) load ctrl0_o, ctrl1_o, ctrl2_o and ctrl3_o. The values at positions 1 to 5 have no effect on any register.
- R4: Each byte is received most significant bit first. The first data bit sampled on SCL rising becomes bit 7.
- R5: For each accepted byte (a matching address and the nine positions after it), sda_pull_o goes high after the SCL fall that follows the eighth rising edge. It returns low after the next SCL fall.
- R6: Bytes after the tenth of a transfer are not acknowledged and change no register.
- R7: A stop, or a repeated start, before the tenth byte ends the transfer. Registers loaded from fully received bytes keep their new values. A partly received byte changes nothing. A following transfer is handled normally.
- R8: A register takes its new value within four system clocks of the eighth SCL rising edge of its byte. It does not wait for the stop condition.
- R9: sda_pull_o is low during every data bit of every byte and while the bus is idle. It is high only in acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain acknowledge) |
| ctrl0_o | output | 8 | Control register loaded from payload byte 3 |
| ctrl1_o | output | 8 | Control register loaded from payload byte 4 |
| ctrl2_o | output | 8 | Control register loaded from payload byte 5 |
| ctrl3_o | output | 8 | Control register loaded from payload byte 6 |

## Verification
A wrong bit count or byte position shows up within one byte. The acknowledge pulse then appears in the wrong slot, or it is missing, on the byte where the count first slips. The payload also lands in the wrong control register as soon as that byte completes, and the wrong value is visible on the ports within four system clocks. A stale address decision shows up at once as an acknowledge, or a missing one, on the first byte. An abort that does not reset the position counter shows up on the first byte of the next transfer.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    localparam int BYTE_W        = 8;
    localparam int NUM_REGS      = 4;
    localparam int REG_IDX_W     = $clog2(NUM_REGS);
    localparam int FRAME_BYTES   = 10;
    localparam int FIRST_REG_POS = 6;
    localparam logic [BYTE_W-1:0] DEV_ADDR = 8'hD2;

    // Events on the bus, taken after synchronisation
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_BITS,
        LK_ACK_ARM,
        LK_ACK_HOLD,
        LK_SKIP
    } link_state_t;

    typedef struct packed {
        logic                 en;
        logic [REG_IDX_W-1:0] idx;
        logic [BYTE_W-1:0]    data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int unsigned i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h43;
            2:       return 8'hEF;
            3:       return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync
    import cfgrx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    always_comb begin
        evt.scl      = scl_pipe[TOP];
        evt.sda      = sda_pipe[TOP];
        evt.scl_rise = scl_pipe[TOP] & ~scl_prev;
        evt.scl_fall = ~scl_pipe[TOP] & scl_prev;
        evt.start    = scl_pipe[TOP] & scl_prev & sda_prev & ~sda_pipe[TOP];
        evt.stop     = scl_pipe[TOP] & scl_prev & ~sda_prev & sda_pipe[TOP];
    end

    // A start or stop needs SCL held high, so it never coincides with an SCL edge
    assert_evt_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.start, evt.stop, evt.scl_rise, evt.scl_fall}));

endmodule

// File: rtl/cfgrx_link.sv
module cfgrx_link
    import cfgrx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ADDR        = DEV_ADDR,
    parameter int                FRAME_LEN   = FRAME_BYTES,
    parameter int                REG_POS     = FIRST_REG_POS
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    output logic      sda_pull,
    output reg_wr_t   wr
);
    localparam int POS_W = $clog2(FRAME_LEN + 1);
    localparam int CNT_W = $clog2(BYTE_W);

    link_state_t       st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [POS_W-1:0]  byte_pos;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              last_bit;
    logic              accept;

    assign next_byte = {shreg, evt.sda};
    assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign accept    = (byte_pos == '0) ? (next_byte == ADDR)
                                        : (byte_pos < POS_W'(FRAME_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LK_IDLE;
            bit_cnt  <= '0;
            byte_pos <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            st       <= LK_BITS;
            bit_cnt  <= '0;
            byte_pos <= '0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            st       <= LK_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                LK_BITS: if (evt.scl_rise) begin
                    shreg <= next_byte[BYTE_W-2:0];
                    if (last_bit) begin
                        bit_cnt <= '0;
                        st      <= accept ? LK_ACK_ARM : LK_SKIP;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                LK_ACK_ARM: if (evt.scl_fall) begin
                    sda_pull <= 1'b1;
                    st       <= LK_ACK_HOLD;
                end
                LK_ACK_HOLD: if (evt.scl_fall) begin
                    sda_pull <= 1'b0;
                    byte_pos <= byte_pos + POS_W'(1);
                    st       <= LK_BITS;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr.en   = (st == LK_BITS) && evt.scl_rise && last_bit
                  && !evt.start && !evt.stop
                  && (byte_pos >= POS_W'(REG_POS))
                  && (byte_pos <  POS_W'(FRAME_LEN));
        wr.idx  = REG_IDX_W'(byte_pos - POS_W'(REG_POS));
        wr.data = next_byte;
    end

    // The pull is switched only while SCL is low
    assert_pull_moves_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !evt.scl);

    // No pull while a data bit is being sampled
    assert_no_pull_on_data_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_rise && st == LK_BITS) |-> !sda_pull);

endmodule

// File: rtl/cfgrx_regs.sv
module cfgrx_regs
    import cfgrx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  reg_wr_t                        wr,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= reg_default(g);
            else if (wr.en && wr.idx == REG_IDX_W'(g))
                q[g] <= wr.data;
        end
    end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfgrx_pkg::*;
#(
    parameter logic [7:0] ADDR        = DEV_ADDR,
    parameter int         FRAME_LEN   = FRAME_BYTES,
    parameter int         REG_POS     = FIRST_REG_POS,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] ctrl0_o,
    output logic [7:0] ctrl1_o,
    output logic [7:0] ctrl2_o,
    output logic [7:0] ctrl3_o
);
    line_evt_t                      evt;
    reg_wr_t                        wr;
    logic [NUM_REGS-1:0][BYTE_W-1:0] ctrl_q;

    cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    cfgrx_link #(.ADDR(ADDR), .FRAME_LEN(FRAME_LEN), .REG_POS(REG_POS)) u_link (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sda_pull (sda_pull_o),
        .wr       (wr)
    );

    cfgrx_regs u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .q   (ctrl_q)
    );

    assign ctrl0_o = ctrl_q[0];
    assign ctrl1_o = ctrl_q[1];
    assign ctrl2_o = ctrl_q[2];
    assign ctrl3_o = ctrl_q[3];

    // A register write happens only on the sampling edge of a byte's last bit
    assert_commit_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> evt.scl_rise);

    // Without a write the control registers hold
    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(ctrl_q));

endmodule

// File: tb/cfg_serial_rx_test.sv
module cfg_serial_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       sda_line;
    logic [7:0] c0, c1, c2, c3;
    int         checks = 0;
    int         fails = 0;
    int         bit_viol = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    cfg_serial_rx uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .ctrl0_o    (c0),
        .ctrl1_o    (c1),
        .ctrl2_o    (c2),
        .ctrl3_o    (c3)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req, input logic [7:0] e0, e1, e2, e3);
        check(req, {c0, c1, c2, c3}, {e0, e1, e2, e3});
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        tick(4);
        scl_m = 1'b1;
        tick(4);
        if (sda_pull) bit_viol++;
        tick(4);
        scl_m = 1'b0;
        tick(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(4);
        scl_m = 1'b1;
        tick(4);
        sda_m = 1'b0;
        tick(4);
        scl_m = 1'b0;
        tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(4);
        scl_m = 1'b1;
        tick(4);
        sda_m = 1'b1;
        tick(8);
    endtask

    // One byte plus its acknowledge slot, with ack and release checks
    task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
        int  viol0;
        bit  acked;
        viol0 = bit_viol;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1;
        tick(4);
        scl_m = 1'b1;
        tick(4);
        acked = (sda_line == 1'b0);
        tick(4);
        scl_m = 1'b0;
        tick(6);
        check(req, {31'd0, acked}, {31'd0, exp_ack});
        check("R5 pull released after slot", {31'd0, sda_pull}, 32'd0);
        check("R9 no pull during data bits", bit_viol - viol0, 32'd0);
    endtask

    task automatic send_frame(input logic [7:0] r0, r1, r2, r3);
        xfer(8'hD2, 1'b1, "R5 ack address");
        xfer(8'h5A, 1'b1, "R5 ack command");
        xfer(8'hC3, 1'b1, "R5 ack count");
        xfer(8'hFF, 1'b1, "R5 ack payload0");
        xfer(8'h81, 1'b1, "R5 ack payload1");
        xfer(8'h7E, 1'b1, "R5 ack payload2");
        xfer(r0, 1'b1, "R5 ack payload3");
        xfer(r1, 1'b1, "R5 ack payload4");
        xfer(r2, 1'b1, "R5 ack payload5");
        xfer(r3, 1'b1, "R5 ack payload6");
    endtask

    task automatic t_reset();
        check_regs("R1 defaults", 8'h00, 8'h43, 8'hEF, 8'h13);
        check("R1 pull low at reset", {31'd0, sda_pull}, 32'd0);
    endtask

    task automatic t_full_write();
        bus_start();
        send_frame(8'h12, 8'h34, 8'h56, 8'h78);
        bus_stop();
        check_regs("R3 payload 3..6 to ctrl0..3", 8'h12, 8'h34, 8'h56, 8'h78);
        check("R4 msb first", {24'd0, c0}, 32'h12);
        check("R9 idle no pull", {31'd0, sda_pull}, 32'd0);
    endtask

    task automatic t_bad_address();
        bus_start();
        xfer(8'hD3, 1'b0, "R2 no ack direction bit set");
        for (int i = 0; i < 9; i++) xfer(8'hA5, 1'b0, "R2 no ack after mismatch");
        bus_stop();
        check_regs("R2 regs unchanged", 8'h12, 8'h34, 8'h56, 8'h78);
        bus_start();
        xfer(8'h52, 1'b0, "R2 no ack msb differs");
        xfer(8'h00, 1'b0, "R2 no ack after mismatch");
        bus_stop();
        check_regs("R2 regs unchanged", 8'h12, 8'h34, 8'h56, 8'h78);
    endtask

    task automatic t_extra_bytes();
        bus_start();
        send_frame(8'h9A, 8'hBC, 8'hDE, 8'hF0);
        xfer(8'h11, 1'b0, "R6 eleventh byte not acked");
        xfer(8'h22, 1'b0, "R6 twelfth byte not acked");
        bus_stop();
        check_regs("R6 extra bytes ignored", 8'h9A, 8'hBC, 8'hDE, 8'hF0);
    endtask

    task automatic t_abort();
        bus_start();
        xfer(8'hD2, 1'b1, "R5 ack address");
        xfer(8'h00, 1'b1, "R5 ack command");
        xfer(8'h00, 1'b1, "R5 ack count");
        for (int i = 0; i < 3; i++) xfer(8'h33, 1'b1, "R5 ack payload0..2");
        xfer(8'hAA, 1'b1, "R5 ack payload3");
        check("R8 ctrl0 updated before stop", {24'd0, c0}, 32'hAA);
        xfer(8'hBB, 1'b1, "R5 ack payload4");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        check_regs("R7 repeated start keeps complete bytes", 8'hAA, 8'hBB, 8'hDE, 8'hF0);
        xfer(8'hD2, 1'b1, "R7 new transfer after repeated start");
        xfer(8'h01, 1'b1, "R7 position restarted");
        xfer(8'h02, 1'b1, "R7 position restarted");
        xfer(8'h03, 1'b1, "R7 position restarted");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        check_regs("R7 stop mid-byte changes nothing", 8'hAA, 8'hBB, 8'hDE, 8'hF0);
        bus_start();
        send_frame(8'h01, 8'h02, 8'h04, 8'h08);
        bus_stop();
        check_regs("R7 normal after abort", 8'h01, 8'h02, 8'h04, 8'h08);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset();
        t_full_write();
        t_bad_address();
        t_extra_bytes();
        t_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule